// File: doc/BRIEF.md
# Loop Exit Predictor

This block recognises counted loop branches and predicts the iteration on which they leave the loop. It holds a tagged, two-way set-associative table with 64 sets. Each entry records a learned trip count and a running iteration count. A loop branch is taken while the body repeats and not taken once on exit. The table learns how many taken outcomes come before the exit. It then predicts not-taken on exactly that iteration.

The lookup port is purely combinational. It takes a conditional branch address and returns a hit flag, a confidence flag and the predicted direction. A surrounding predictor may use the prediction only when the confidence flag is set. The update port takes the resolved branch address and its outcome. It changes the table on the next rising clock edge, so a lookup in the following cycle sees the new state.

A branch that is not yet in the table is allocated only when it resolves not-taken, which is the outcome opposite to the taken direction of a loop body. The first full run after allocation captures the trip count. A second run with the same count makes the entry confident. A loop whose count would pass the 6-bit counter range is marked untrainable.

Top module: `loop_exit_predictor`

## Requirements
- R1: After reset every lookup misses, and hit, confidence and predicted direction are all 0.
- R2: The set index is IP[9:4] and the tag is IP[15:10]. IP bits [3:0] and [31:16] do not affect a lookup. An address with the same index but a different tag misses.
- R3: An update that misses and resolves not-taken allocates an entry: the next lookup hits with confidence 0 and predicts taken (1). An update that misses and resolves taken allocates nothing.
- R4: The first not-taken outcome after allocation stores, as the trip count, the number of taken outcomes seen since allocation. Confidence stays 0.
- R5: A hitting entry predicts taken, except when it holds a trip count and its current count equals that trip count; then it predicts not-taken (0).
- R6: A not-taken outcome on a trained entry sets confidence when the current count equals the trip count. Otherwise it stores the current count as the new trip count and clears confidence.
- R7: Every not-taken outcome on a hitting entry returns its current count to 0.
- R8: A taken outcome arriving when the current count is 63 marks the entry untrainable. From then on it keeps hitting and never reports confidence. A trip count of exactly 63 is still learned and predicted.
- R9: Allocation fills the lowest-numbered invalid way of the set; if both ways are valid, it replaces the least recently used way. Each update that hits or allocates makes its way the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_ip_i | input | 32 | Lookup branch address |
| lk_hit_o | output | 1 | Lookup address has a valid entry |
| lk_conf_o | output | 1 | Entry is confident and trainable |
| lk_pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| up_valid_i | input | 1 | Update strobe |
| up_ip_i | input | 32 | Resolved branch address |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A corrupted current count shows up on the lookup port during the next loop run. The not-taken prediction lands on the wrong iteration, at most one trip count after the fault. A wrong trip count or confidence update shows at the exit: confidence either fails to rise after a repeated run or stays high after a mismatched one, which is visible in the cycle after the exit update. A wrong replacement choice shows as a miss on a recently used branch in the cycle after the allocation. The bench therefore samples the lookup port after every chosen update, not only at loop boundaries.

// File: rtl/lp_pkg.sv
package lp_pkg;
  parameter int unsigned CNT_W = 6;
  parameter int unsigned TAG_W = 6;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] max_cnt;
    logic [CNT_W-1:0] cur_cnt;
    logic             trained;
    logic             conf;
    logic             dead;
  } lp_entry_t;
endpackage

// File: rtl/lp_way_match.sv
module lp_way_match
  import lp_pkg::*;
#(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned WAY_W = 1
) (
  input  lp_entry_t [WAYS-1:0] set_i,
  input  logic [TAG_W-1:0]     tag_i,
  output logic                 hit_o,
  output logic [WAY_W-1:0]     way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_i[w].valid && (set_i[w].tag == tag_i);
  end

  always_comb begin
    hit_o = |match;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) way_o = WAY_W'(w);
  end
endmodule

// File: rtl/lp_entry_next.sv
module lp_entry_next
  import lp_pkg::*;
(
  input  lp_entry_t cur_i,
  input  logic      taken_i,
  output lp_entry_t nxt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_comb begin
    nxt_o = cur_i;
    if (taken_i) begin
      if (!cur_i.dead) begin
        if (cur_i.cur_cnt == CntMax) begin
          nxt_o.dead = 1'b1;           // loop longer than counter range
          nxt_o.conf = 1'b0;
        end else begin
          nxt_o.cur_cnt = cur_i.cur_cnt + 1'b1;
        end
      end
    end else begin
      nxt_o.cur_cnt = '0;
      if (!cur_i.dead) begin
        if (cur_i.trained && cur_i.cur_cnt == cur_i.max_cnt) begin
          nxt_o.conf = 1'b1;
        end else begin
          nxt_o.max_cnt = cur_i.cur_cnt;
          nxt_o.trained = 1'b1;
          nxt_o.conf    = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lp_lru.sv
module lp_lru #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned WAY_W = 1,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [WAY_W-1:0] touch_way_i
);
  logic [WAY_W-1:0] lru_q [SETS];

  assign victim_o = lru_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (touch_i) begin
      lru_q[touch_idx_i] <= (touch_way_i == WAY_W'(WAYS - 1)) ? '0 : touch_way_i + 1'b1;
    end
  end

  // R9: a touched way never stays the replacement candidate
  assert_lru_moves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> lru_q[$past(touch_idx_i)] != $past(touch_way_i));
endmodule

// File: rtl/loop_exit_predictor.sv
module loop_exit_predictor
  import lp_pkg::*;
#(
  parameter int unsigned IP_W    = 32,
  parameter int unsigned IDX_LSB = 4,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned WAYS    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IP_W-1:0] lk_ip_i,
  output logic            lk_hit_o,
  output logic            lk_conf_o,
  output logic            lk_pred_taken_o,
  input  logic            up_valid_i,
  input  logic [IP_W-1:0] up_ip_i,
  input  logic            up_taken_i
);
  localparam int unsigned SETS    = 1 << IDX_W;
  localparam int unsigned TAG_LSB = IDX_LSB + IDX_W;
  localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  lp_entry_t tbl_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lk_ip_i[IDX_LSB +: IDX_W];
  assign lk_tag = lk_ip_i[TAG_LSB +: TAG_W];
  assign up_idx = up_ip_i[IDX_LSB +: IDX_W];
  assign up_tag = up_ip_i[TAG_LSB +: TAG_W];

  logic unused_ip_bits;
  assign unused_ip_bits = ^{lk_ip_i, up_ip_i};

  lp_entry_t [WAYS-1:0] lk_set, up_set;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_set[w] = tbl_q[lk_idx][w];
      up_set[w] = tbl_q[up_idx][w];
    end
  end

  // lookup side
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  lp_entry_t        lk_ent;

  lp_way_match #(.WAYS(WAYS), .WAY_W(WAY_W)) i_lk_match (
    .set_i(lk_set), .tag_i(lk_tag), .hit_o(lk_hit), .way_o(lk_way)
  );

  assign lk_ent          = lk_set[lk_way];
  assign lk_hit_o        = lk_hit;
  assign lk_conf_o       = lk_hit && lk_ent.conf && !lk_ent.dead;
  assign lk_pred_taken_o = lk_hit && !(lk_ent.trained && lk_ent.cur_cnt == lk_ent.max_cnt);

  // update side
  logic             up_hit;
  logic [WAY_W-1:0] up_way, lru_way, vict;
  lp_entry_t        up_nxt, alloc_ent;

  lp_way_match #(.WAYS(WAYS), .WAY_W(WAY_W)) i_up_match (
    .set_i(up_set), .tag_i(up_tag), .hit_o(up_hit), .way_o(up_way)
  );

  lp_entry_next i_next (.cur_i(up_set[up_way]), .taken_i(up_taken_i), .nxt_o(up_nxt));

  always_comb begin
    vict = lru_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!up_set[w].valid) vict = WAY_W'(w);
  end

  always_comb begin
    alloc_ent       = '0;
    alloc_ent.valid = 1'b1;
    alloc_ent.tag   = up_tag;
  end

  logic do_alloc, touch;
  assign do_alloc = up_valid_i && !up_hit && !up_taken_i;
  assign touch    = (up_valid_i && up_hit) || do_alloc;

  lp_lru #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W)) i_lru (
    .clk_i, .rst_ni,
    .rd_idx_i(up_idx), .victim_o(lru_way),
    .touch_i(touch), .touch_idx_i(up_idx), .touch_way_i(up_hit ? up_way : vict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) tbl_q[s][w] <= '0;
    end else if (up_valid_i) begin
      if (up_hit)        tbl_q[up_idx][up_way] <= up_nxt;
      else if (do_alloc) tbl_q[up_idx][vict]   <= alloc_ent;
    end
  end

  // R3: allocation lands in the chosen way with the update tag
  assert_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_alloc |=> tbl_q[$past(up_idx)][$past(vict)].valid
             && tbl_q[$past(up_idx)][$past(vict)].tag == $past(up_tag));

  // R3: taken miss leaves the set untouched
  for (genvar w = 0; w < WAYS; w++) begin : g_chk
    assert_no_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_valid_i && !up_hit && up_taken_i)
        |=> tbl_q[$past(up_idx)][w] == $past(tbl_q[up_idx][w]));
  end

  // R7: exit clears the running count
  assert_exit_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_hit && !up_taken_i) |=> tbl_q[$past(up_idx)][$past(up_way)].cur_cnt == '0);

  // R8: counter overflow kills the entry
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_hit && up_taken_i && up_set[up_way].cur_cnt == CntMax)
      |=> tbl_q[$past(up_idx)][$past(up_way)].dead && !tbl_q[$past(up_idx)][$past(up_way)].conf);

  // R6: mismatched exit drops confidence
  assert_conf_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_hit && !up_taken_i && up_set[up_way].trained
      && up_set[up_way].cur_cnt != up_set[up_way].max_cnt)
      |=> !tbl_q[$past(up_idx)][$past(up_way)].conf);
endmodule

// File: tb/test_loop_exit_predictor.sv
module test_loop_exit_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_ip = '0;
  logic        lk_hit, lk_conf, lk_pred;
  logic        up_valid = 1'b0;
  logic [31:0] up_ip = '0;
  logic        up_taken = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  loop_exit_predictor i_loop_exit_predictor (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_ip_i(lk_ip), .lk_hit_o(lk_hit), .lk_conf_o(lk_conf), .lk_pred_taken_o(lk_pred),
    .up_valid_i(up_valid), .up_ip_i(up_ip), .up_taken_i(up_taken)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [2:0] exp_q[$];
  string      name_q[$];

  function automatic logic [31:0] mk_ip(int tag, int idx);
    return 32'((tag << 10) | (idx << 4));
  endfunction

  // driver side
  task automatic upd(logic [31:0] ip, logic tk);
    @(posedge clk); #1;
    up_valid = 1'b1; up_ip = ip; up_taken = tk;
    @(posedge clk); #1;
    up_valid = 1'b0;
  endtask

  task automatic run(logic [31:0] ip, int n);
    for (int i = 0; i < n; i++) upd(ip, 1'b1);
  endtask

  task automatic chk(logic [31:0] ip, logic h, logic c, logic p, string nm);
    @(posedge clk); #1;
    lk_ip = ip;
    exp_q.push_back({h, c, p});
    name_q.push_back(nm);
    @(negedge clk); #1;
  endtask

  // monitor side
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string nm;
      e  = exp_q.pop_front();
      nm = name_q.pop_front();
      checks++;
      if ({lk_hit, lk_conf, lk_pred} !== e) begin
        fails++;
        $display("FAIL %s: hit/conf/pred actual %b expected %b", nm, {lk_hit, lk_conf, lk_pred}, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ip_a, ip_b, ip_c, s_a, s_b, s_c;
    ip_a = mk_ip(5, 3);
    ip_b = mk_ip(9, 20);
    ip_c = mk_ip(11, 21);
    s_a  = mk_ip(1, 40);
    s_b  = mk_ip(2, 40);
    s_c  = mk_ip(3, 40);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk(ip_a, 0, 0, 0, "R1 reset miss");
    upd(ip_a, 1'b1);
    chk(ip_a, 0, 0, 0, "R3 taken miss no alloc");
    upd(ip_a, 1'b0);
    chk(ip_a, 1, 0, 1, "R3 alloc on not-taken");

    run(ip_a, 5);
    chk(ip_a, 1, 0, 1, "R5 untrained predicts taken");
    upd(ip_a, 1'b0);
    chk(ip_a, 1, 0, 1, "R4 trip count captured, R7 count cleared");
    run(ip_a, 4);
    chk(ip_a, 1, 0, 1, "R5 before exit iteration");
    run(ip_a, 1);
    chk(ip_a, 1, 0, 0, "R5 exit iteration predicted not-taken");
    upd(ip_a, 1'b0);
    chk(ip_a, 1, 1, 1, "R6 matching exit sets confidence");

    chk(ip_a | 32'h0010_000F, 1, 1, 1, "R2 low and high bits ignored");
    chk(mk_ip(6, 3), 0, 0, 0, "R2 different tag misses");

    run(ip_a, 3);
    chk(ip_a, 1, 1, 1, "R5 confident mid loop");
    upd(ip_a, 1'b0);
    chk(ip_a, 1, 0, 1, "R6 early exit clears confidence");
    run(ip_a, 3);
    chk(ip_a, 1, 0, 0, "R6 retrained trip count 3");
    upd(ip_a, 1'b0);
    chk(ip_a, 1, 1, 1, "R6 retrained confident");

    upd(ip_b, 1'b0);
    run(ip_b, 63);
    chk(ip_b, 1, 0, 1, "R8 count at 63");
    run(ip_b, 1);
    chk(ip_b, 1, 0, 1, "R8 overflow entry still hits");
    upd(ip_b, 1'b0);
    for (int k = 0; k < 2; k++) begin
      run(ip_b, 5);
      upd(ip_b, 1'b0);
    end
    chk(ip_b, 1, 0, 1, "R8 untrainable never confident");

    upd(ip_c, 1'b0);
    run(ip_c, 63);
    upd(ip_c, 1'b0);
    run(ip_c, 63);
    chk(ip_c, 1, 0, 0, "R8 trip count 63 predicted");
    upd(ip_c, 1'b0);
    chk(ip_c, 1, 1, 1, "R8 trip count 63 confident");

    upd(s_a, 1'b0);
    upd(s_b, 1'b0);
    upd(s_a, 1'b1);
    upd(s_c, 1'b0);
    chk(s_a, 1, 0, 1, "R9 recently used way kept");
    chk(s_b, 0, 0, 0, "R9 lru way replaced");
    chk(s_c, 1, 0, 1, "R9 new entry present");
    upd(s_b, 1'b0);
    chk(s_a, 0, 0, 0, "R9 second replacement evicts older way");
    chk(s_b, 1, 0, 1, "R9 reallocated entry present");
    chk(s_c, 1, 0, 1, "R9 mru entry kept");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule